// File: doc/BRIEF.md
# Multi-Style Port Status LED Driver

This block turns the per-port status of an eight-port Ethernet PHY into LED drive signals. Each port reports four conditions: link up, traffic activity, 100 Mbit/s speed and full duplex. A static configuration input selects one of three output styles. The first style sends every LED state over one serial line, with a shift clock and a latch strobe. The second style gives every LED of every port its own pin. The third style drives one two-colour LED per port.

A second static input controls how the activity indication is shaped. It can pass through unchanged, be held on for a minimum time after each burst of traffic, or flash from a divider shared by all ports. The shaping applies in all three output styles.

All LED outputs are active-low. The serial clock and the strobe are active-high.

Top module: `ledCtrl`

## Requirements
- R1: While reset is asserted, and after its release until a mode drives them, every LED output (parLedN, biLedAN, biLedBN, serData) is high, serClk is low and serStrobe is low. The first serial bit sent after reset is frame bit 0.
- R2: With outMode = 1 (parallel), parLedN[4*p+i] equals the inverse of LED i of port p one clock after the inputs. The LED index i is: 0 = link, 1 = conditioned activity, 2 = speed, 3 = duplex.
- R3: With outMode = 0 (serial), serClk has a period of SHIFT_DIV system clocks. It is low for the first half of each period and high for the second half. serData changes only in the cycle in which serClk falls, so it is stable across every rising edge.
- R4: A serial frame is 33 shift periods long. The first 32 periods carry frame bits k = 4*p+i in ascending k, each bit active-low and using the same LED index as R2. The 33rd period has serStrobe high for the whole period and serData high. Frames repeat without a gap.
- R5: With outMode = 2 (bicolor), port p behaves as follows. With no link, both biLedAN[p] and biLedBN[p] are high. With link and no conditioned activity, only biLedAN[p] is low. With link and conditioned activity, only biLedBN[p] is low. The two outputs of a port are never low together.
- R6: Outputs of a style that is not selected stay off: LED pins high, serClk and serStrobe low. outMode = 3 turns every output off.
- R7: With actMode = 0 or 3 (plain), the conditioned activity equals actIn.
- R8: With actMode = 1 (stretch), conditioned activity stays on for STRETCH_CYCLES cycles after the last cycle in which actIn was sampled high. A new pulse during that time restarts the hold.
- R9: With actMode = 2 (blink), the conditioned activity of a port whose actIn is high alternates between on and off every BLINK_HALF cycles. The rate comes from one divider shared by all ports. The conditioned activity is off while actIn is low.
- R10: The activity shaping selected by actMode applies in every output style, including the bicolor activity colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outMode | input | 2 | Output style: 0 serial, 1 parallel, 2 bicolor, 3 off |
| actMode | input | 2 | Activity shaping: 0 plain, 1 stretch, 2 blink, 3 plain |
| linkIn | input | NUM_PORTS | Link-up status per port |
| actIn | input | NUM_PORTS | Raw activity per port |
| speedIn | input | NUM_PORTS | High-speed status per port |
| duplexIn | input | NUM_PORTS | Full-duplex status per port |
| serData | output | 1 | Serial LED data, active-low |
| serClk | output | 1 | Serial shift clock |
| serStrobe | output | 1 | Serial frame latch strobe |
| parLedN | output | 4*NUM_PORTS | Per-LED outputs, active-low |
| biLedAN | output | NUM_PORTS | Bicolor colour A (link idle), active-low |
| biLedBN | output | NUM_PORTS | Bicolor colour B (activity), active-low |

## Verification
The assertions assume that outMode and actMode are quasi-static. The stretch check tolerates a mode change, but the serial clock and data checks assume the style does not toggle in mid-period to fake a data change while serClk is high. The bench changes modes only between test phases and waits for at least one full serial frame before capturing. Status inputs change only at falling system-clock edges. For the serial captures they are held constant across the whole frame, so the snapshot taken at bit 0 equals what the bench expects.

// File: rtl/ledCtrlPkg.sv
package ledCtrlPkg;

  localparam int LEDS_PER_PORT = 4;
  localparam int LED_LINK      = 0;
  localparam int LED_ACT       = 1;
  localparam int LED_SPEED     = 2;
  localparam int LED_DUPLEX    = 3;

  typedef enum logic [1:0] {
    OUT_SERIAL   = 2'd0,
    OUT_PARALLEL = 2'd1,
    OUT_BICOLOR  = 2'd2,
    OUT_NONE     = 2'd3
  } outStyleE;

  typedef enum logic [1:0] {
    ACT_PLAIN   = 2'd0,
    ACT_STRETCH = 2'd1,
    ACT_BLINK   = 2'd2,
    ACT_RSVD    = 2'd3
  } actStyleE;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic slotStart;  // first system cycle of a shift period
    logic clkHigh;    // second half of a shift period
    logic frameEnd;   // current slot is the latch slot
    logic blinkOn;    // shared blink phase
  } tickS;

endpackage

// File: rtl/ledCtrlTiming.sv
module ledCtrlTiming
  import ledCtrlPkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int SHIFT_DIV  = 16,
  parameter int BLINK_HALF = 6250000,
  parameter int SLOT_W     = $clog2(NUM_PORTS * LEDS_PER_PORT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  output tickS              tick,
  output logic [SLOT_W-1:0] slotIdx
);

  localparam int FRAME_BITS = NUM_PORTS * LEDS_PER_PORT;
  localparam int DIV_W      = (SHIFT_DIV > 2) ? $clog2(SHIFT_DIV) : 1;
  localparam int BLK_W      = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SHIFT_DIV - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(SHIFT_DIV / 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_BITS);
  localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(BLINK_HALF - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [BLK_W-1:0]  blinkCnt;
  logic              blinkOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      slotCnt <= '0;
    end else if (divCnt == DIV_LAST) begin
      divCnt  <= '0;
      slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt <= '0;
      blinkOn  <= 1'b1;
    end else if (blinkCnt == BLK_LAST) begin
      blinkCnt <= '0;
      blinkOn  <= ~blinkOn;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  assign tick.slotStart = (divCnt == '0);
  assign tick.clkHigh   = (divCnt >= DIV_HALF);
  assign tick.frameEnd  = (slotCnt == SLOT_LAST);
  assign tick.blinkOn   = blinkOn;
  assign slotIdx        = slotCnt;

  // R4: slot counter never leaves the frame
  a_r4_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= SLOT_LAST);

  // R4: slot only moves at the end of a shift period
  a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt != DIV_LAST) |=> $stable(slotCnt));

  // R9: blink phase only flips when the shared divider wraps
  a_r9_blink_hold: assert property (@(posedge clk) disable iff (!rstN)
    (blinkCnt != BLK_LAST) |=> $stable(blinkOn));

endmodule

// File: rtl/ledCtrlData.sv
module ledCtrlData
  import ledCtrlPkg::*;
#(
  parameter int NUM_PORTS      = 8,
  parameter int STRETCH_CYCLES = 1 << 22,
  parameter int SLOT_W         = $clog2(NUM_PORTS * LEDS_PER_PORT + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  outStyleE                           outStyle,
  input  actStyleE                           actStyle,
  input  logic [NUM_PORTS-1:0]               linkIn,
  input  logic [NUM_PORTS-1:0]               actIn,
  input  logic [NUM_PORTS-1:0]               speedIn,
  input  logic [NUM_PORTS-1:0]               duplexIn,
  input  tickS                               tick,
  input  logic [SLOT_W-1:0]                  slotIdx,
  output logic                               serData,
  output logic                               serClk,
  output logic                               serStrobe,
  output logic [NUM_PORTS*LEDS_PER_PORT-1:0] parLedN,
  output logic [NUM_PORTS-1:0]               biLedAN,
  output logic [NUM_PORTS-1:0]               biLedBN
);

  localparam int FRAME_BITS = NUM_PORTS * LEDS_PER_PORT;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int STR_W      = $clog2(STRETCH_CYCLES + 1);
  localparam logic [STR_W-1:0] STR_LOAD = STR_W'(STRETCH_CYCLES);

  logic [NUM_PORTS-1:0]  actCond;
  logic [FRAME_BITS-1:0] ledVec;
  logic [FRAME_BITS-1:0] frameReg;
  logic [IDX_W-1:0]      bitIdx;
  logic                  bitVal;
  logic                  serialSel, parallelSel, bicolorSel;

  assign serialSel   = (outStyle == OUT_SERIAL);
  assign parallelSel = (outStyle == OUT_PARALLEL);
  assign bicolorSel  = (outStyle == OUT_BICOLOR);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [STR_W-1:0] holdCnt;
    logic             stretched;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                holdCnt <= '0;
      else if (actIn[p])        holdCnt <= STR_LOAD;
      else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
    end

    assign stretched = actIn[p] | (holdCnt != '0);

    always_comb begin
      unique case (actStyle)
        ACT_STRETCH: actCond[p] = stretched;
        ACT_BLINK:   actCond[p] = actIn[p] & tick.blinkOn;
        default:     actCond[p] = actIn[p];
      endcase
    end

    assign ledVec[p*LEDS_PER_PORT + LED_LINK]   = linkIn[p];
    assign ledVec[p*LEDS_PER_PORT + LED_ACT]    = actCond[p];
    assign ledVec[p*LEDS_PER_PORT + LED_SPEED]  = speedIn[p];
    assign ledVec[p*LEDS_PER_PORT + LED_DUPLEX] = duplexIn[p];

    // R8: a sampled pulse keeps the parallel activity LED lit two cycles on
    a_r8_stretch_min: assert property (@(posedge clk) disable iff (!rstN)
      (actStyle == ACT_STRETCH && outStyle == OUT_PARALLEL && actIn[p])
      |=> ##1 ($past(actStyle) != ACT_STRETCH || $past(outStyle) != OUT_PARALLEL
               || !parLedN[p*LEDS_PER_PORT + LED_ACT]));
  end

  assign bitIdx = slotIdx[IDX_W-1:0];
  assign bitVal = (slotIdx == '0) ? ledVec[0] : frameReg[bitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg  <= '0;
      serData   <= 1'b1;
      serClk    <= 1'b0;
      serStrobe <= 1'b0;
      parLedN   <= '1;
      biLedAN   <= '1;
      biLedBN   <= '1;
    end else begin
      if (tick.slotStart && slotIdx == '0) frameReg <= ledVec;
      serClk <= serialSel & tick.clkHigh;
      if (!serialSel) begin
        serData   <= 1'b1;
        serStrobe <= 1'b0;
      end else if (tick.slotStart) begin
        serStrobe <= tick.frameEnd;
        serData   <= tick.frameEnd ? 1'b1 : ~bitVal;
      end
      parLedN <= parallelSel ? ~ledVec : '1;
      biLedAN <= bicolorSel ? ~(linkIn & ~actCond) : '1;
      biLedBN <= bicolorSel ? ~(linkIn & actCond) : '1;
    end
  end

  // R5: both colours of one port never lit together
  a_r5_bicolor_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    &(biLedAN | biLedBN));

  // R6: serial pins idle whenever serial style was not selected
  a_r6_serial_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outStyle) != OUT_SERIAL) |-> (serData && !serClk && !serStrobe));

  // R3: data only moves while the shift clock is low
  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (serData != $past(serData)) |-> !serClk);

  // R4: latch slot carries no lit LED
  a_r4_strobe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    serStrobe |-> serData);

endmodule

// File: rtl/ledCtrl.sv
module ledCtrl
  import ledCtrlPkg::*;
#(
  parameter int NUM_PORTS      = 8,
  parameter int SHIFT_DIV      = 16,
  parameter int STRETCH_CYCLES = 1 << 22,
  parameter int BLINK_HALF     = 6250000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               outMode,
  input  logic [1:0]               actMode,
  input  logic [NUM_PORTS-1:0]     linkIn,
  input  logic [NUM_PORTS-1:0]     actIn,
  input  logic [NUM_PORTS-1:0]     speedIn,
  input  logic [NUM_PORTS-1:0]     duplexIn,
  output logic                     serData,
  output logic                     serClk,
  output logic                     serStrobe,
  output logic [4*NUM_PORTS-1:0]   parLedN,
  output logic [NUM_PORTS-1:0]     biLedAN,
  output logic [NUM_PORTS-1:0]     biLedBN
);

  localparam int SLOT_W = $clog2(NUM_PORTS * LEDS_PER_PORT + 1);

  tickS              tick;
  logic [SLOT_W-1:0] slotIdx;

  ledCtrlTiming #(
    .NUM_PORTS (NUM_PORTS),
    .SHIFT_DIV (SHIFT_DIV),
    .BLINK_HALF(BLINK_HALF),
    .SLOT_W    (SLOT_W)
  ) u_timing (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .slotIdx(slotIdx)
  );

  ledCtrlData #(
    .NUM_PORTS     (NUM_PORTS),
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .SLOT_W        (SLOT_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .outStyle (outStyleE'(outMode)),
    .actStyle (actStyleE'(actMode)),
    .linkIn   (linkIn),
    .actIn    (actIn),
    .speedIn  (speedIn),
    .duplexIn (duplexIn),
    .tick     (tick),
    .slotIdx  (slotIdx),
    .serData  (serData),
    .serClk   (serClk),
    .serStrobe(serStrobe),
    .parLedN  (parLedN),
    .biLedAN  (biLedAN),
    .biLedBN  (biLedBN)
  );

endmodule

// File: tb/ledCtrl_tb.sv
module ledCtrl_tb;

  localparam int NP  = 8;
  localparam int NB  = 4 * NP;
  localparam int DIV = 4;
  localparam int STR = 20;
  localparam int BLK = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    outMode = 2'd0;
  logic [1:0]    actMode = 2'd0;
  logic [NP-1:0] linkIn = '0, actIn = '0, speedIn = '0, duplexIn = '0;
  logic          serData, serClk, serStrobe;
  logic [NB-1:0] parLedN;
  logic [NP-1:0] biLedAN, biLedBN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  ledCtrl #(
    .NUM_PORTS(NP), .SHIFT_DIV(DIV), .STRETCH_CYCLES(STR), .BLINK_HALF(BLK)
  ) u_dut (
    .clk(clk), .rstN(rstN), .outMode(outMode), .actMode(actMode),
    .linkIn(linkIn), .actIn(actIn), .speedIn(speedIn), .duplexIn(duplexIn),
    .serData(serData), .serClk(serClk), .serStrobe(serStrobe),
    .parLedN(parLedN), .biLedAN(biLedAN), .biLedBN(biLedBN)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] expVec(input logic [NP-1:0] l, a, s, d);
    logic [NB-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[4*p+0] = l[p];
      v[4*p+1] = a[p];
      v[4*p+2] = s[p];
      v[4*p+3] = d[p];
    end
    return v;
  endfunction

  // captures one full serial frame starting after a latch slot
  task automatic grabFrame(output logic [NB-1:0] got, output bit endOk,
                           output bit dataOk, output bit midOk);
    logic prev, prevD;
    int   n, guard;
    got = '0; endOk = 0; dataOk = 1; midOk = 1; guard = 0;
    prev = serClk;
    forever begin
      tick(); guard++;
      if (!prev && serClk && serStrobe) break;
      if (guard > 2000) break;
      prev = serClk;
    end
    prev = serClk; prevD = serData; n = 0;
    while (n < NB + 1 && guard < 4000) begin
      tick(); guard++;
      if (serData != prevD && serClk) dataOk = 0;
      if (!prev && serClk) begin
        if (n < NB) begin
          got[n] = serData;
          if (serStrobe) midOk = 0;
        end else begin
          endOk = serStrobe && serData;
        end
        n++;
      end
      prev = serClk; prevD = serData;
    end
  endtask

  initial begin
    logic [NB-1:0] ev, got;
    bit   endOk, dataOk, midOk;
    int   cnt, trans, hi, lo;
    logic prev;
    logic [NP-1:0] l, a;

    // R1: reset state
    outMode = 2'd0; linkIn = 8'h01;
    repeat (3) tick();
    chk(parLedN == '1 && biLedAN == '1 && biLedBN == '1, "R1 led pins off in reset",
        {parLedN, biLedAN, biLedBN}, '1);
    chk(serData && !serClk && !serStrobe, "R1 serial pins in reset",
        {serData, serClk, serStrobe}, 3'b100);
    rstN = 1'b1;
    prev = serClk;
    cnt = 0;
    while (!( !prev && serClk) && cnt < 50) begin prev = serClk; tick(); cnt++; end
    chk(serData == 1'b0 && !serStrobe, "R1 first bit after reset is bit 0",
        {serStrobe, serData}, 2'b00);

    // R3: shift clock shape
    while (serClk) tick();
    while (!serClk) tick();
    hi = 0; while (serClk) begin hi++; tick(); end
    lo = 0; while (!serClk) begin lo++; tick(); end
    chk(hi == DIV/2 && lo == DIV/2, "R3 shift clock period", {hi[31:0], lo[31:0]},
        {32'(DIV/2), 32'(DIV/2)});

    // R4 R3: serial frames for several patterns
    for (int i = 0; i < 4; i++) begin
      linkIn = 8'(i * 77 + 5); actIn = 8'(i * 39 + 2);
      speedIn = 8'(i * 141 + 9); duplexIn = 8'(~(i * 23));
      ev = expVec(linkIn, actIn, speedIn, duplexIn);
      grabFrame(got, endOk, dataOk, midOk);
      chk(got == ~ev, "R4 serial frame bits", got, ~ev);
      chk(endOk && midOk, "R4 latch slot after 32 bits", {endOk, midOk}, 2'b11);
      chk(dataOk, "R3 data stable while shift clock high", dataOk, 1);
      chk(parLedN == '1 && biLedAN == '1 && biLedBN == '1, "R6 other styles off in serial",
          {parLedN, biLedAN}, '1);
    end

    // R2 R7: parallel sweep, plain activity
    outMode = 2'd1; actMode = 2'd0;
    for (int i = 0; i < 64; i++) begin
      linkIn = 8'(i * 37 + 1); actIn = 8'(i * 91 + 3);
      speedIn = 8'(i * 13); duplexIn = 8'(~(i * 29));
      tick(); tick();
      ev = expVec(linkIn, actIn, speedIn, duplexIn);
      chk(parLedN == ~ev, "R2 R7 parallel pattern", parLedN, ~ev);
    end
    chk(serData && !serClk && !serStrobe && biLedAN == '1 && biLedBN == '1,
        "R6 serial and bicolor off in parallel", {serData, serClk, serStrobe}, 3'b100);

    // R8: single pulse stretch
    linkIn = '0; actIn = '0; speedIn = '0; duplexIn = '0;
    actMode = 2'd1;
    repeat (STR + 5) tick();
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      actIn[3] = (i == 0);
      tick();
      if (!parLedN[13]) cnt++;
      if (parLedN[5] == 1'b0) cnt += 1000;
    end
    chk(cnt == STR + 1, "R8 single pulse on-time", cnt, STR + 1);
    // R8: retrigger restarts hold
    cnt = 0;
    for (int i = 0; i < 70; i++) begin
      actIn[3] = (i == 0 || i == 10);
      tick();
      if (!parLedN[13]) cnt++;
    end
    chk(cnt == 10 + STR + 1, "R8 retrigger on-time", cnt, 10 + STR + 1);

    // R7 R10: reserved activity code behaves as plain
    actMode = 2'd3;
    repeat (STR + 5) tick();
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      actIn[3] = (i == 0);
      tick();
      if (!parLedN[13]) cnt++;
    end
    chk(cnt == 1, "R7 reserved code is plain", cnt, 1);

    // R9: blink
    actMode = 2'd2; actIn = 8'h20;
    tick();
    cnt = 0; trans = 0; prev = parLedN[21];
    for (int i = 0; i < 8 * BLK; i++) begin
      tick();
      if (!parLedN[21]) cnt++;
      if (parLedN[21] != prev) trans++;
      prev = parLedN[21];
    end
    chk(cnt == 4 * BLK, "R9 blink duty", cnt, 4 * BLK);
    chk(trans == 7 || trans == 8, "R9 blink toggle rate", trans, 8);
    actIn = '0;
    cnt = 0;
    tick();
    for (int i = 0; i < 4 * BLK; i++) begin tick(); if (!parLedN[21]) cnt++; end
    chk(cnt == 0, "R9 idle port dark in blink", cnt, 0);

    // R5: bicolor sweep, plain
    outMode = 2'd2; actMode = 2'd0;
    for (int i = 0; i < 32; i++) begin
      l = 8'(i * 53); a = 8'(i * 101 + 7);
      linkIn = l; actIn = a;
      tick(); tick();
      chk(biLedAN == ~(l & ~a) && biLedBN == ~(l & a), "R5 bicolor encoding",
          {biLedAN, biLedBN}, {~(l & ~a), ~(l & a)});
    end
    chk(parLedN == '1 && serData && !serClk && !serStrobe, "R6 others off in bicolor",
        parLedN, '1);

    // R10: stretch applies to bicolor colour B
    actMode = 2'd1; linkIn = 8'h01; actIn = '0;
    repeat (STR + 5) tick();
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      actIn[0] = (i == 0);
      tick();
      if (!biLedBN[0]) cnt++;
    end
    chk(cnt == STR + 1, "R10 stretch in bicolor", cnt, STR + 1);

    // R6: off style
    outMode = 2'd3; linkIn = '1; actIn = '1; speedIn = '1; duplexIn = '1;
    cnt = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      tick();
      if (parLedN != '1 || biLedAN != '1 || biLedBN != '1 || !serData || serClk || serStrobe)
        cnt++;
    end
    chk(cnt == 0, "R6 all outputs off in style 3", cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule